// File: doc/BRIEF.md
# Video Pre-Amplifier Control Register Bank with Two-Wire Slave

This block is the serial control front end of a video pre-amplifier. It watches a two-wire bus on SCL and SDA and oversamples both lines with the system clock. It answers one fixed 7-bit device address, 0x6E. It drives SDA only as an open-drain pull-down enable. A write transfer carries a register pointer and then any number of data bytes. A read transfer returns bytes starting at the pointer left by an earlier pointer-only write.

The bank holds sixteen 8-bit registers, and each one starts from its own default. All sixteen are presented in parallel to the video path. Register n sits at bits [8n+7:8n] of the output vector. The pointer steps after every byte unless a control bit stops it. A self-clearing soft-reset bit reloads all the other registers without breaking the transfer in flight. Holding values until vertical blank is left to the block that follows.

Top module: `vid_ctl_regbank`

## Requirements
- R1: An address byte whose upper seven bits equal 0x6E is acknowledged: 0xDC selects write and 0xDD selects read. Any other address byte gets no acknowledge, and SDA stays released for the rest of that transfer until the next START.
- R2: In a write transfer the slave acknowledges the address byte, a pointer byte and every data byte. Each data byte lands in the register the pointer selects and shows on the parallel output.
- R3: While bit 0 of register 0x0A is 0, the pointer advances by one after each data byte written or read. Only the low four pointer bits are used, so 0x0F is followed by 0x00.
- R4: While bit 0 of register 0x0A is 1, the pointer holds. Further bytes of a write go to the same register, and further bytes of a read return the same register.
- R5: A read is set up by a write transfer that carries only the pointer, followed by STOP. A new START with 0xDD then returns bytes MSB first from that pointer. The master acknowledges each byte except the last, which it NACKs.
- R6: After reset the registers hold 0x60 at 0x00-0x03, 0x80 at 0x04-0x07, 0x15 at 0x08 and 0x04 at 0x0B. Every other register holds 0x00.
- R7: Reserved bits always read as 0. These are bit 7 of 0x00-0x03, bits [7:5] of 0x08 (bits [4:3] carry OSD contrast and bits [2:0] the DC offset) and bits [7:1] of 0x0F.
- R8: Writes to 0x0C, 0x0D and 0x0E are acknowledged and have no effect, and these addresses read as 0x00.
- R9: Writing 1 to bit 0 of 0x0F reloads every other register with its default one clock later, and the bit is clear again in that same clock. The bus transfer carrying it goes on, so a following byte in the same transfer is still written.
- R10: A START seen partway through a byte restarts address reception. A STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| regs_o | output | 128 | All registers in parallel, register n at bits [8n+7:8n] |

## Verification
A soft-reset reload and the ongoing bus transfer that wrote it act in the same window. The reload clock falls inside the acknowledge phase of the byte that set the bit. In that same clock the pointer has just wrapped from 0x0F to 0x00 and the engine is holding SDA low. The bench sends one write transfer whose pointer is 0x0F and whose data is 0x01 and then 0x55. It then checks that registers written earlier in the run have returned to their defaults, that 0x0F reads 0, that every byte was acknowledged, and that register 0x00 holds 0x55.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WR,
    ST_RD,
    ST_RACK
  } eng_state_t;

  localparam int SRST_IDX = 15;
  localparam int AINC_IDX = 10;

  function automatic logic [7:0] reg_default(input int idx);
    logic [7:0] v;
    if (idx <= 3)       v = 8'h60;
    else if (idx <= 7)  v = 8'h80;
    else if (idx == 8)  v = 8'h15;
    else if (idx == 11) v = 8'h04;
    else                v = 8'h00;
    return v;
  endfunction

  function automatic logic [7:0] reg_mask(input int idx);
    logic [7:0] m;
    if (idx <= 3)                    m = 8'h7F;
    else if (idx == 8)               m = 8'h1F;
    else if (idx >= 12 && idx <= 14) m = 8'h00;
    else if (idx == SRST_IDX)        m = 8'h01;
    else                             m = 8'hFF;
    return m;
  endfunction

endpackage

// File: rtl/vcr_line_sync.sv
module vcr_line_sync #(
  parameter int SYNC_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_p_o,
  output logic stop_p_o
);
  logic [SYNC_W-1:0] scl_pipe_q, sda_pipe_q;
  logic              scl_prev_q, sda_prev_q;
  logic              scl_s, sda_s;

  assign scl_s = scl_pipe_q[SYNC_W-1];
  assign sda_s = sda_pipe_q[SYNC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[SYNC_W-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[SYNC_W-2:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
  assign start_p_o  = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_p_o   = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/vcr_bus_engine.sv
module vcr_bus_engine
  import vcr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6E,
  parameter int         IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_p_i,
  input  logic             stop_p_i,
  input  logic             ainc_off_i,
  input  logic [7:0]       rd_data_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o,
  output logic             idle_o
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  eng_state_t       state_q, state_n;
  logic [3:0]       cnt_q, cnt_n;
  logic             ack_q, ack_n;
  logic [7:0]       shr_q, shr_n;
  logic [7:0]       tx_q, tx_n;
  logic [IDX_W-1:0] ptr_q, ptr_n;
  logic             oe_q, oe_n;
  logic             mack_q, mack_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    ack_n   = ack_q;
    shr_n   = shr_q;
    tx_n    = tx_q;
    ptr_n   = ptr_q;
    oe_n    = oe_q;
    mack_n  = mack_q;
    wr_en_o = 1'b0;
    if (stop_p_i) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
      ack_n   = 1'b0;
    end else if (start_p_i) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
      ack_n   = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_PTR, ST_WR: begin
          if (ack_q) begin
            if (scl_fall_i) begin
              ack_n = 1'b0;
              oe_n  = 1'b0;
            end
          end else if (scl_rise_i && cnt_q != BYTE_BITS) begin
            shr_n = {shr_q[6:0], sda_s_i};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall_i && cnt_q == BYTE_BITS) begin
            cnt_n = '0;
            ack_n = 1'b1;
            oe_n  = 1'b1;
            case (state_q)
              ST_ADDR: begin
                if (shr_q[7:1] == DEV_ADDR) begin
                  state_n = shr_q[0] ? ST_RD : ST_PTR;
                end else begin
                  state_n = ST_IDLE;
                  ack_n   = 1'b0;
                  oe_n    = 1'b0;
                end
              end
              ST_PTR: begin
                ptr_n   = shr_q[IDX_W-1:0];
                state_n = ST_WR;
              end
              default: begin
                wr_en_o = 1'b1;
                if (!ainc_off_i) ptr_n = ptr_q + 1'b1;
              end
            endcase
          end
        end
        ST_RD: begin
          if (ack_q) begin
            if (scl_fall_i) begin
              ack_n = 1'b0;
              tx_n  = rd_data_i;
              oe_n  = ~rd_data_i[7];
              cnt_n = '0;
            end
          end else if (scl_rise_i && cnt_q != BYTE_BITS) begin
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall_i) begin
            if (cnt_q == BYTE_BITS) begin
              oe_n    = 1'b0;
              mack_n  = 1'b0;
              state_n = ST_RACK;
              if (!ainc_off_i) ptr_n = ptr_q + 1'b1;
            end else begin
              tx_n = {tx_q[6:0], 1'b0};
              oe_n = ~tx_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            mack_n = ~sda_s_i;
          end else if (scl_fall_i) begin
            if (mack_q) begin
              state_n = ST_RD;
              tx_n    = rd_data_i;
              oe_n    = ~rd_data_i[7];
              cnt_n   = '0;
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      shr_q   <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      ack_q   <= ack_n;
      shr_q   <= shr_n;
      tx_q    <= tx_n;
      ptr_q   <= ptr_n;
      oe_q    <= oe_n;
      mack_q  <= mack_n;
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_data_o = shr_q;
  assign sda_oe_o  = oe_q;
  assign idle_o    = (state_q == ST_IDLE);
endmodule

// File: rtl/vcr_regfile.sv
module vcr_regfile
  import vcr_pkg::*;
#(
  parameter int REG_CNT = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [7:0]         wr_data_i,
  output logic [7:0]         rd_data_o,
  output logic               ainc_off_o,
  output logic [REG_CNT*8-1:0] regs_o
);
  logic [7:0] rq [REG_CNT];
  logic       srst;

  assign srst = rq[SRST_IDX][0];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    localparam logic [7:0] DFLT = reg_default(g);
    localparam logic [7:0] MASK = reg_mask(g);
    logic       hit;
    logic [7:0] d;
    assign hit = wr_en_i && (idx_i == IDX_W'(g));
    if (g == SRST_IDX) begin : g_self_clear
      always_comb d = hit ? (wr_data_i & MASK) : 8'h00;
    end else begin : g_plain
      always_comb begin
        d = rq[g];
        if (srst)     d = DFLT;
        else if (hit) d = wr_data_i & MASK;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rq[g] <= DFLT;
      else        rq[g] <= d;
    end
    assign regs_o[8*g +: 8] = rq[g];
  end

  assign rd_data_o  = rq[idx_i];
  assign ainc_off_o = rq[AINC_IDX][0];
endmodule

// File: rtl/vid_ctl_regbank.sv
module vid_ctl_regbank #(
  parameter logic [6:0] DEV_ADDR = 7'h6E,
  parameter int         REG_CNT  = 16,
  parameter int         SYNC_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [REG_CNT*8-1:0] regs_o
);
  localparam int IDX_W = $clog2(REG_CNT);

  logic [1:0]       rst_pipe_q;
  logic             rst_q_n;
  logic             sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic             ainc_off, wr_en, eng_idle;
  logic [7:0]       rd_data, wr_data;
  logic [IDX_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  vcr_line_sync #(.SYNC_W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_p_o(start_p), .stop_p_o(stop_p)
  );

  vcr_bus_engine #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst_n(rst_q_n), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_p_i(start_p), .stop_p_i(stop_p),
    .ainc_off_i(ainc_off), .rd_data_i(rd_data),
    .ptr_o(ptr), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .sda_oe_o(sda_oe_o), .idle_o(eng_idle)
  );

  vcr_regfile #(.REG_CNT(REG_CNT), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst_n(rst_q_n), .wr_en_i(wr_en), .idx_i(ptr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .ainc_off_o(ainc_off),
    .regs_o(regs_o)
  );
endmodule

// File: rtl/vcr_checker.sv
module vcr_checker (
  input logic         clk,
  input logic         rst_n,
  input logic [127:0] regs,
  input logic         sda_oe,
  input logic         start_p,
  input logic         stop_p,
  input logic         eng_idle
);
  // R1: an idle slave (including after a wrong address) never pulls SDA
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !sda_oe);

  // R10: a START always leaves SDA released
  p_start_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !sda_oe);

  // R10: a STOP always returns the engine to idle
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> eng_idle);

  // R9: the soft-reset bit never stays set for two clocks
  p_srst_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    regs[120] |=> !regs[120]);

  // R9: the clock after the bit is seen, defaults are back
  p_srst_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    regs[120] |=> (regs[7:0] == 8'h60 && regs[39:32] == 8'h80 &&
                   regs[71:64] == 8'h15 && regs[95:88] == 8'h04));

  // R7: reserved bits stay zero
  p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !regs[7] && !regs[15] && !regs[23] && !regs[31] &&
    regs[71:69] == 3'b000 && regs[127:121] == 7'd0);

  // R8: unimplemented addresses hold zero
  p_hole_r8: assert property (@(posedge clk) disable iff (!rst_n)
    regs[119:96] == 24'd0);
endmodule

bind vid_ctl_regbank vcr_checker u_chk (
  .clk(clk), .rst_n(rst_q_n), .regs(regs_o), .sda_oe(sda_oe_o),
  .start_p(start_p), .stop_p(stop_p), .eng_idle(eng_idle)
);

// File: tb/vid_ctl_regbank_test.sv
module vid_ctl_regbank_test;
  localparam int Q = 5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         scl_m, sda_m;
  logic         sda_line;
  logic         sda_oe;
  logic [127:0] regs;
  int           nchk = 0;
  int           nfail = 0;
  logic [7:0]   rbuf [16];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  vid_ctl_regbank uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  // ptr, data written, expected value in the register
  localparam logic [23:0] VEC [8] = '{
    24'h00FF7F, 24'h038000, 24'h04A5A5, 24'h08FF1F,
    24'h0C7700, 24'h0E1200, 24'h0B3C3C, 24'h09C3C3
  };

  function automatic logic [7:0] exp_dflt(input int i);
    if (i <= 3)  return 8'h60;
    if (i <= 7)  return 8'h80;
    if (i == 8)  return 8'h15;
    if (i == 11) return 8'h04;
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq();
    scl_m = 1'b1; wq(); wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    b = sda_line; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic last, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(last);
  endtask

  // write n (1..3) data bytes starting at ptr; ok=all acknowledged
  task automatic wr_txn(input logic [7:0] ptr, input int n,
                        input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, output logic ok);
    logic a;
    ok = 1'b1;
    bus_start();
    wbyte(8'hDC, a); ok &= a;
    wbyte(ptr, a);   ok &= a;
    wbyte(d0, a);    ok &= a;
    if (n > 1) begin wbyte(d1, a); ok &= a; end
    if (n > 2) begin wbyte(d2, a); ok &= a; end
    bus_stop();
  endtask

  task automatic rd_txn(input logic [7:0] ptr, input int n, output logic ok);
    logic a;
    logic [7:0] v;
    ok = 1'b1;
    bus_start();
    wbyte(8'hDC, a); ok &= a;
    wbyte(ptr, a);   ok &= a;
    bus_stop();
    bus_start();
    wbyte(8'hDD, a); ok &= a;
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, v);
      rbuf[i] = v;
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic ok, a;
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R6: defaults on the parallel outputs
    for (int i = 0; i < 16; i++) check("R6 reset default", regs[8*i +: 8], exp_dflt(i));
    check("R6 SDA released after reset", {7'd0, sda_oe}, 8'h00);

    // R5 R3: read all sixteen registers in one transfer
    rd_txn(8'h00, 16, ok);
    check("R5 read acks", {7'd0, ok}, 8'h01);
    for (int i = 0; i < 16; i++) check("R5 R3 sequential read", rbuf[i], exp_dflt(i));

    // R2 R7 R8: vector table
    for (int k = 0; k < 8; k++) begin
      wr_txn(VEC[k][23:16], 1, VEC[k][15:8], 8'h00, 8'h00, ok);
      check("R2 R8 write acked", {7'd0, ok}, 8'h01);
      check("R2 R7 R8 parallel output", regs[8*int'(VEC[k][19:16]) +: 8], VEC[k][7:0]);
      rd_txn(VEC[k][23:16], 1, ok);
      check("R5 R7 R8 read back", rbuf[0], VEC[k][7:0]);
    end

    // R3: multi-byte write with auto-increment
    wr_txn(8'h05, 3, 8'h11, 8'h22, 8'h33, ok);
    check("R3 acks", {7'd0, ok}, 8'h01);
    check("R3 reg05", regs[40 +: 8], 8'h11);
    check("R3 reg06", regs[48 +: 8], 8'h22);
    check("R3 reg07", regs[56 +: 8], 8'h33);

    // R9 R3: soft reset mid-transfer, pointer wraps to 0x00
    wr_txn(8'h0F, 2, 8'h01, 8'h55, 8'h00, ok);
    check("R9 transfer acked", {7'd0, ok}, 8'h01);
    check("R9 R3 byte after reset lands at 0x00", regs[0 +: 8], 8'h55);
    check("R9 reg04 reloaded", regs[32 +: 8], 8'h80);
    check("R9 reg05 reloaded", regs[40 +: 8], 8'h80);
    check("R9 reg08 reloaded", regs[64 +: 8], 8'h15);
    check("R9 reg09 reloaded", regs[72 +: 8], 8'h00);
    check("R9 reg0B reloaded", regs[88 +: 8], 8'h04);
    check("R9 self clear", regs[120 +: 8], 8'h00);

    // R4: auto-increment off
    wr_txn(8'h0A, 1, 8'h01, 8'h00, 8'h00, ok);
    wr_txn(8'h05, 2, 8'h11, 8'h22, 8'h00, ok);
    check("R4 acks", {7'd0, ok}, 8'h01);
    check("R4 reg05 takes last byte", regs[40 +: 8], 8'h22);
    check("R4 reg06 untouched", regs[48 +: 8], 8'h80);
    rd_txn(8'h05, 2, ok);
    check("R4 read first", rbuf[0], 8'h22);
    check("R4 read repeats", rbuf[1], 8'h22);
    wr_txn(8'h0A, 1, 8'h00, 8'h00, 8'h00, ok);

    // R1: wrong address, rest of the transfer ignored
    bus_start();
    wbyte(8'hDE, a);
    check("R1 wrong address NACK", {7'd0, a}, 8'h00);
    wbyte(8'h05, a);
    check("R1 pointer after NACK ignored", {7'd0, a}, 8'h00);
    wbyte(8'h99, a);
    check("R1 data after NACK ignored", {7'd0, a}, 8'h00);
    bus_stop();
    check("R1 reg05 unchanged", regs[40 +: 8], 8'h22);

    // R10: START mid-byte restarts address reception
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    wbyte(8'hDC, a); ok = a;
    wbyte(8'h07, a); ok &= a;
    wbyte(8'h5A, a); ok &= a;
    bus_stop();
    check("R10 restart acks", {7'd0, ok}, 8'h01);
    check("R10 reg07 written", regs[56 +: 8], 8'h5A);
    check("R10 SDA released after STOP", {7'd0, sda_oe}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule